// File: doc/BRIEF.md
# Message Interrupt Pending-Bit Updater

This block maintains the pending state of message-signalled interrupts, held as a bit array in memory with one bit per interrupt ID. A requester presents a 32-bit interrupt ID and an operation code: set the pending bit, clear it, or only report it. The block checks that the ID is in range, reads the byte that holds the bit through a byte-wide memory port, edits that one bit, and writes the byte back. A query performs only the read.

The block is a five-state controller. The states are IDLE, READ, MODIFY, WRITE and DONE. The transitions are:
- IDLE→READ when an in-range request is accepted.
- IDLE→DONE when a request is out of range and is rejected.
- READ→MODIFY always.
- MODIFY→WRITE when the bit must change.
- MODIFY→DONE for a query, or when the bit already holds the requested value.
- WRITE→DONE always.
- DONE→IDLE always.

The block is busy from the cycle after it accepts a request until the cycle after `done`. Requests presented while it is busy are ignored.

Top module: `msi_pend_updater`

## Requirements
- R1: The byte for ID n is read and written at address `cfg_base + (n >> 3)`, which wraps modulo 2^ADDR_W. The bit edited inside that byte is bit position `n[2:0]`.
- R2: A set request (`req_op` = 2'd1) writes back the read byte OR'd with the addressed bit. The other seven bits keep their values.
- R3: A clear request (`req_op` = 2'd2) writes back the read byte AND'd with the inverse of the addressed bit.
- R4: A query (`req_op` = 2'd0, and also 2'd3) reads the byte and reports the addressed bit on `resp_pending`. It never writes memory.
- R5: IDs below 8192 are rejected. The block reports `resp_rejected`=1 with `done` in the cycle after acceptance and makes no memory access.
- R6: IDs greater than `1 << (cfg_id_bits + 1)` are rejected in the same way as R5. An ID equal to that limit is accepted.
- R7: When the bit already holds the requested value, the write-back is skipped and `resp_wrote`=0. When the bit changes, `resp_wrote`=1.
- R8: `busy` is high from the cycle after acceptance up to and including the `done` cycle. Requests presented while `busy` is high are ignored and have no effect on memory.
- R9: Measured from the accepting clock edge, `done` rises for one cycle after 1 edge for a rejected request, after 3 edges when no write-back is made, and after 4 edges when a write-back is made. `resp_pending` reports the bit value as it was read, before any edit.
- R10: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; sampled only while idle |
| req_op | input | 2 | 0 query, 1 set, 2 clear, 3 query |
| req_id | input | 32 | Interrupt ID |
| cfg_id_bits | input | 5 | ID-width setting; limit is 1 << (value+1) |
| cfg_base | input | 32 | Byte address of the pending table |
| mem_rd_en | output | 1 | Byte read strobe; data is returned one cycle later |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd_en |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_pending | output | 1 | Addressed bit value as read |
| resp_rejected | output | 1 | Request was out of range |
| resp_wrote | output | 1 | A write-back was made |

## Verification
The assertions check several properties on every cycle:
- reads and writes are never issued together;
- a write goes to the same address as the read two cycles earlier;
- the written byte differs from the read byte in exactly one bit;
- a write is always followed by `done`;
- a rejection comes straight from idle;
- `done` is a single-cycle pulse, and `busy` holds until `done`.

Other behaviour can only be shown by the bench's scenarios, run against its own memory model:
- the correct byte contents after mixed set, clear and query sequences;
- the exact boundaries of the ID range at several ID-width settings;
- the skipped write-backs;
- the latency counts;
- the refusal of requests that arrive during an operation.

// File: rtl/msi_pend_pkg.sv
package msi_pend_pkg;

    typedef enum logic [1:0] {
        OP_QUERY = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_PEEK  = 2'd3
    } pend_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } pend_state_e;

    localparam int unsigned MIN_MSG_ID = 8192;

endpackage

// File: rtl/msi_pend_range_chk.sv
module msi_pend_range_chk #(
    parameter int unsigned ID_W     = 32,
    parameter int unsigned IDBITS_W = 5,
    parameter int unsigned MIN_ID   = 8192
) (
    input  logic [ID_W-1:0]     id,
    input  logic [IDBITS_W-1:0] id_bits,
    output logic                in_range
);
    localparam int unsigned LIM_W = ID_W + 2;

    logic [IDBITS_W:0] shift_amt;
    logic [LIM_W-1:0]  limit;
    logic [LIM_W-1:0]  id_ext;
    logic              above_min;
    logic              below_max;

    always_comb begin
        shift_amt = {1'b0, id_bits} + {{IDBITS_W{1'b0}}, 1'b1};
        limit     = {{(LIM_W-1){1'b0}}, 1'b1} << shift_amt;
        id_ext    = {2'b00, id};
        above_min = id_ext >= LIM_W'(MIN_ID);
        below_max = id_ext <= limit;
        in_range  = above_min && below_max;
    end
endmodule

// File: rtl/msi_pend_addr_gen.sv
module msi_pend_addr_gen #(
    parameter int unsigned ID_W   = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [$clog2(BYTE_W)-1:0] bit_sel
);
    localparam int unsigned SEL_W = $clog2(BYTE_W);

    logic [ID_W-1:0] byte_idx;

    always_comb begin
        byte_idx  = id >> SEL_W;
        byte_addr = base + ADDR_W'(byte_idx);
        bit_sel   = id[SEL_W-1:0];
    end
endmodule

// File: rtl/msi_pend_bit_edit.sv
module msi_pend_bit_edit #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]         old_byte,
    input  logic [$clog2(BYTE_W)-1:0] bit_sel,
    input  logic                      set_op,
    output logic [BYTE_W-1:0]         new_byte,
    output logic                      old_bit,
    output logic                      change_needed
);
    logic [BYTE_W-1:0] hit;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign hit[g]      = (bit_sel == g);
        assign new_byte[g] = hit[g] ? set_op : old_byte[g];
    end

    always_comb begin
        old_bit       = |(old_byte & hit);
        change_needed = old_bit != set_op;
    end
endmodule

// File: rtl/msi_pend_updater.sv
module msi_pend_updater
    import msi_pend_pkg::*;
#(
    parameter int unsigned ID_W     = 32,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned IDBITS_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ID_W-1:0]     req_id,
    input  logic [IDBITS_W-1:0] cfg_id_bits,
    input  logic [ADDR_W-1:0]   cfg_base,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                resp_pending,
    output logic                resp_rejected,
    output logic                resp_wrote
);
    localparam int unsigned SEL_W = $clog2(BYTE_W);

    pend_state_e state_q, state_d;

    logic              accept;
    logic              in_range;
    logic [ADDR_W-1:0] addr_next;
    logic [SEL_W-1:0]  sel_next;

    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel_q;
    logic              is_set_q;
    logic              is_edit_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              pend_q;
    logic              rej_q;
    logic              wrote_q;

    logic [BYTE_W-1:0] edit_byte;
    logic              edit_old_bit;
    logic              edit_change;

    msi_pend_range_chk #(
        .ID_W    (ID_W),
        .IDBITS_W(IDBITS_W),
        .MIN_ID  (MIN_MSG_ID)
    ) u_range (
        .id      (req_id),
        .id_bits (cfg_id_bits),
        .in_range(in_range)
    );

    msi_pend_addr_gen #(
        .ID_W  (ID_W),
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) u_addr (
        .id       (req_id),
        .base     (cfg_base),
        .byte_addr(addr_next),
        .bit_sel  (sel_next)
    );

    msi_pend_bit_edit #(
        .BYTE_W(BYTE_W)
    ) u_edit (
        .old_byte     (mem_rdata),
        .bit_sel      (sel_q),
        .set_op       (is_set_q),
        .new_byte     (edit_byte),
        .old_bit      (edit_old_bit),
        .change_needed(edit_change)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = in_range ? ST_READ : ST_DONE;
            ST_READ:   state_d = ST_MODIFY;
            ST_MODIFY: state_d = (is_edit_q && edit_change) ? ST_WRITE : ST_DONE;
            ST_WRITE:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            sel_q     <= '0;
            is_set_q  <= 1'b0;
            is_edit_q <= 1'b0;
            wdata_q   <= '0;
            pend_q    <= 1'b0;
            rej_q     <= 1'b0;
            wrote_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q    <= addr_next;
                sel_q     <= sel_next;
                is_set_q  <= (req_op == OP_SET);
                is_edit_q <= (req_op == OP_SET) || (req_op == OP_CLEAR);
                rej_q     <= !in_range;
                pend_q    <= 1'b0;
                wrote_q   <= 1'b0;
            end
            if (state_q == ST_MODIFY) begin
                pend_q  <= edit_old_bit;
                wdata_q <= edit_byte;
                wrote_q <= is_edit_q && edit_change;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd_en     = 1'b0;
        mem_wr_en     = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        mem_addr      = addr_q;
        mem_wdata     = wdata_q;
        resp_pending  = pend_q;
        resp_rejected = rej_q;
        resp_wrote    = wrote_q;
        unique case (state_q)
            ST_IDLE:   busy      = 1'b0;
            ST_READ:   mem_rd_en = 1'b1;
            ST_MODIFY: ;
            ST_WRITE:  mem_wr_en = 1'b1;
            ST_DONE:   done      = 1'b1;
            default:   busy      = 1'b0;
        endcase
    end

    p_rdwr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_wr_same_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == $past(mem_addr, 2)) && $past(mem_rd_en, 2));

    p_single_bit_edit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wdata ^ $past(mem_rdata)) == 1));

    p_write_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done);

    p_reject_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_rejected) |-> !$past(busy));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_no_write_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !resp_wrote) |-> !$past(mem_wr_en));

endmodule

// File: tb/msi_pend_updater_tb_top.sv
module msi_pend_updater_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_id = '0;
    logic [4:0]  cfg_id_bits = 5'd15;
    logic [31:0] cfg_base = 32'h1000_0000;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done, resp_pending, resp_rejected, resp_wrote;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int writes = 0;
    int reads = 0;

    logic [7:0] mem [int unsigned];
    logic [7:0] ref_mem [int unsigned];

    always #2 clk = ~clk;

    msi_pend_updater dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_id(req_id), .cfg_id_bits(cfg_id_bits), .cfg_base(cfg_base),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .resp_pending(resp_pending), .resp_rejected(resp_rejected),
        .resp_wrote(resp_wrote)
    );

    // Byte memory, one-cycle read latency
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd_en) begin
            reads <= reads + 1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        end
        if (mem_wr_en) begin
            writes <= writes + 1;
            mem[mem_addr] = mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ok(input logic [31:0] id, input logic [4:0] nb);
        longint unsigned lim = 64'd1 << (nb + 1);
        return (id >= 32'd8192) && (longint'(id) <= lim);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] id);
        return cfg_base + (id >> 3);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic do_op(input logic [1:0] op, input logic [31:0] id, input logic [4:0] nb);
        bit ok;
        logic [31:0] a;
        logic [7:0] oldb, newb;
        logic obit, exp_wr;
        int lat, w0, r0;
        ok = exp_ok(id, nb);
        a = exp_addr(id);
        oldb = ref_rd(a);
        obit = oldb[id[2:0]];
        newb = oldb;
        if (op == 2'd1) newb[id[2:0]] = 1'b1;
        if (op == 2'd2) newb[id[2:0]] = 1'b0;
        exp_wr = ok && (newb != oldb);
        if (ok) ref_mem[a] = newb;
        @(negedge clk);
        w0 = writes; r0 = reads;
        cfg_id_bits = nb; req_op = op; req_id = id; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(ok ? "R6 accept" : "R5/R6 reject", resp_rejected, !ok);
        check("R9 latency", lat, !ok ? 1 : (exp_wr ? 4 : 3));
        check("R7 wrote flag", resp_wrote, exp_wr);
        check("R4 pending value", resp_pending, ok ? obit : 1'b0);
        check("R2/R3 byte content", mem_rd(a), ref_rd(a));
        check("R7 write count", writes - w0, exp_wr ? 1 : 0);
        check("R5 read count", reads - r0, ok ? 1 : 0);
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 busy at reset", busy, 0);
        check("R10 done at reset", done, 0);
        check("R10 mem enables at reset", {mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;

        // Directed: R1 addressing, R2 set, R3 clear, R7 skip, R4 query
        do_op(2'd1, 32'd8197, 5'd15);
        check("R1 byte addr bit5", mem_rd(cfg_base + 32'd1024), 8'h20);
        do_op(2'd1, 32'd8197, 5'd15);
        do_op(2'd1, 32'd8192, 5'd15);
        do_op(2'd0, 32'd8197, 5'd15);
        do_op(2'd3, 32'd8198, 5'd15);
        do_op(2'd2, 32'd8197, 5'd15);
        check("R3 clear leaves bit0", mem_rd(cfg_base + 32'd1024), 8'h01);
        do_op(2'd2, 32'd8197, 5'd15);

        // Range boundaries R5/R6
        do_op(2'd1, 32'd8191, 5'd15);
        do_op(2'd1, 32'd0, 5'd15);
        do_op(2'd1, 32'd16384, 5'd13);
        do_op(2'd1, 32'd16385, 5'd13);
        do_op(2'd1, 32'd65536, 5'd15);
        do_op(2'd1, 32'd65537, 5'd15);
        do_op(2'd1, 32'hFFFF_FFFF, 5'd31);
        do_op(2'd0, 32'hFFFF_FFFF, 5'd31);
        do_op(2'd1, 32'h8000_0000, 5'd29);

        // R8: requests during busy are ignored
        begin
            int w0;
            @(negedge clk);
            w0 = writes;
            cfg_id_bits = 5'd15; req_op = 2'd1; req_id = 32'd9000; req_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check("R8 busy after accept", busy, 1);
            req_id = 32'd9601;
            while (!done) @(negedge clk);
            req_valid = 1'b0;
            check("R8 busy during done", busy, 1);
            ref_mem[exp_addr(32'd9000)] = ref_rd(exp_addr(32'd9000)) | 8'h01;
            check("R8 first request applied", mem_rd(exp_addr(32'd9000)), ref_rd(exp_addr(32'd9000)));
            check("R8 busy-time request ignored", mem_rd(exp_addr(32'd9601)), 8'h00);
            check("R8 single write", writes - w0, 1);
            @(negedge clk);
            check("R8 idle after done", busy, 0);
        end

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            logic [31:0] id;
            op = 2'($urandom_range(0, 3));
            id = 32'd8180 + 32'($urandom_range(0, 120));
            do_op(op, id, 5'd15);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule